// File: doc/BRIEF.md
# Dual-Mode Sticky DMA Status Register

This block holds the event flags that a DMA engine raises, together with a small control register that chooses how software acknowledges those flags. Hardware raises a flag with a one-cycle pulse. The flag then stays set until software clears it. Software reaches both registers through a plain register port. The port has an address, a write strobe with write data, and a read strobe with registered read data.

Four flag positions (bits 6, 3, 2 and 1 of the status word) are sticky. One control bit selects how they clear, and software may change it at any time:

- In clear-on-read mode, reading the status word acknowledges every sticky flag that was shown.
- In write-one-to-clear mode, a read has no side effect, and software clears flags by writing ones to their positions.

The other status positions show live level inputs and are untouched by either mode. An interrupt line is high while any sticky flag with its enable set is high.

Top module: `dma_status_clrmode`

## Requirements
- R1: After reset, every sticky flag, the clear-mode bit and all interrupt enables are 0, `irq` is 0, and `bus_rdata` is 0.
- R2: The control word at offset 0x50 holds the clear-mode bit at bit 24 (0 = clear-on-read, 1 = write-one-to-clear) and interrupt enables at bits 6, 3, 2 and 1. All other bits read back as 0, so writing 0xFFFF_FFFF reads back as 0x0100_004E.
- R3: A pulse on `evt_set` at bit 1, 2, 3 or 6 sets that sticky flag. When a set pulse and a clear hit the same flag in the same cycle, the flag stays set.
- R4: With the mode bit at 0, a read of the status word at offset 0x54 clears every sticky flag that has no set pulse in that cycle. Writes to the status word are ignored.
- R5: With the mode bit at 1, reads of the status word leave all flags unchanged. A status write clears exactly the sticky flags whose data bit is 1, so writing 0x02 clears only bit 1.
- R6: In the cycle after a read strobe, `bus_rdata` holds the register value from the strobe cycle, taken before any clear. In the status word, bits 6, 3, 2 and 1 are the sticky flags, bits 7, 5, 4 and 0 are `live_stat` at those positions, and bits 31:8 are 0. Unmapped offsets read as 0, and `bus_rdata` is 0 in cycles that do not follow a read.
- R7: `irq` is the OR of the sticky flags ANDed with their enables. It falls in the cycle after the access that clears the last enabled flag.
- R8: `evt_set` pulses at bits 7, 5, 4 and 0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| evt_set | input | 8 | One-cycle set pulses, one per status position |
| live_stat | input | 8 | Level status shown at the non-sticky positions |
| irq | output | 1 | Interrupt request |

## Verification
The assertions that tie a read or a write to the state of the flags assume that read and write strobes never arrive in the same cycle. They therefore assume that a clear-on-read access is never combined with a write. The stimulus issues exactly one bus access per cycle. It inserts an idle cycle after each access so that the registered read data can be sampled. Set pulses that collide with a clear are driven only in dedicated cycles, and those cycles are checked against the rule that a set wins. The sweep covers both modes, every combination of the four sticky flags, and every write-one-to-clear pattern.

// File: rtl/dmasr_pkg.sv
package dmasr_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int STAT_W = 8;

    localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h50;
    localparam logic [ADDR_W-1:0] STAT_OFS = 8'h54;
    localparam int MODE_POS = 24;
    localparam logic [STAT_W-1:0] STICKY_MASK = 8'h4E;

    typedef enum logic {
        CLR_ON_READ = 1'b0,
        CLR_W1C     = 1'b1
    } clr_mode_e;

    typedef struct packed {
        logic rd_stat;
        logic wr_stat;
        logic rd_ctrl;
        logic wr_ctrl;
    } bus_sel_t;

    typedef struct packed {
        clr_mode_e          mode;
        logic [STAT_W-1:0]  irq_en;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] ctrl_word(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[MODE_POS]     = c.mode;
        w[STAT_W-1:0]   = c.irq_en;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input logic [STAT_W-1:0] s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[STAT_W-1:0] = s;
        return w;
    endfunction

endpackage

// File: rtl/dmasr_decode.sv
module dmasr_decode
    import dmasr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] P_CTRL_OFS = CTRL_OFS,
    parameter logic [ADDR_W-1:0] P_STAT_OFS = STAT_OFS
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bus_sel_t          sel
);

    logic hit_ctrl;
    logic hit_stat;

    always_comb begin
        hit_ctrl    = (addr == P_CTRL_OFS);
        hit_stat    = (addr == P_STAT_OFS);
        sel.rd_stat = rd & hit_stat;
        sel.wr_stat = wr & hit_stat;
        sel.rd_ctrl = rd & hit_ctrl;
        sel.wr_ctrl = wr & hit_ctrl;
    end

endmodule

// File: rtl/dmasr_ctrl_reg.sv
module dmasr_ctrl_reg
    import dmasr_pkg::*;
#(
    parameter int                P_MODE_POS = MODE_POS,
    parameter logic [STAT_W-1:0] P_EN_MASK  = STICKY_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl
);

    ctrl_t ctrl_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.mode   <= CLR_ON_READ;
            ctrl_q.irq_en <= '0;
        end else if (wr_sel) begin
            ctrl_q.mode   <= clr_mode_e'(wdata[P_MODE_POS]);
            ctrl_q.irq_en <= wdata[STAT_W-1:0] & P_EN_MASK;
        end
    end

    assign ctrl = ctrl_q;

    // The mode bit only ever moves on a control write (R2)
    assert_mode_only_by_write_R2: assert property (@(posedge clk) disable iff (rst)
        !$stable(ctrl_q.mode) |-> $past(wr_sel));

    // Enable bits outside the sticky positions stay zero (R2)
    assert_en_confined_R2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.irq_en & ~P_EN_MASK) == '0);

endmodule

// File: rtl/dmasr_sticky_bit.sv
module dmasr_sticky_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_rd,
    input  logic clr_w1c,
    output logic q
);

    logic q_r;
    logic clr_any;

    assign clr_any = clr_rd | clr_w1c;

    always_ff @(posedge clk) begin
        if (rst)
            q_r <= 1'b0;
        else if (set_evt)
            q_r <= 1'b1;
        else if (clr_any)
            q_r <= 1'b0;
    end

    assign q = q_r;

    // A set pulse always leaves the flag high, even against a clear (R3)
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> q_r);

    // A read-side clear with no competing set drops the flag (R4)
    assert_rd_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_rd && !set_evt) |=> !q_r);

    // A write-one clear with no competing set drops the flag (R5)
    assert_w1c_clear_R5: assert property (@(posedge clk) disable iff (rst)
        (clr_w1c && !set_evt) |=> !q_r);

endmodule

// File: rtl/dma_status_clrmode.sv
module dma_status_clrmode
    import dmasr_pkg::*;
#(
    parameter logic [ADDR_W-1:0] P_CTRL_OFS    = CTRL_OFS,
    parameter logic [ADDR_W-1:0] P_STAT_OFS    = STAT_OFS,
    parameter int                P_MODE_POS    = MODE_POS,
    parameter logic [STAT_W-1:0] P_STICKY_MASK = STICKY_MASK
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [STAT_W-1:0] evt_set,
    input  logic [STAT_W-1:0] live_stat,
    output logic              irq
);

    bus_sel_t          sel;
    ctrl_t             ctrl;
    logic [STAT_W-1:0] sticky_q;
    logic [STAT_W-1:0] stat_view;
    logic              clr_rd_en;
    logic              clr_w1c_en;
    logic [DATA_W-1:0] rdata_q;

    logic unused_in;
    assign unused_in = ^{evt_set & ~P_STICKY_MASK, live_stat & P_STICKY_MASK};

    dmasr_decode #(
        .P_CTRL_OFS (P_CTRL_OFS),
        .P_STAT_OFS (P_STAT_OFS)
    ) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .rd   (bus_rd),
        .sel  (sel)
    );

    dmasr_ctrl_reg #(
        .P_MODE_POS (P_MODE_POS),
        .P_EN_MASK  (P_STICKY_MASK)
    ) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .wr_sel (sel.wr_ctrl),
        .wdata  (bus_wdata),
        .ctrl   (ctrl)
    );

    assign clr_rd_en  = sel.rd_stat & (ctrl.mode == CLR_ON_READ);
    assign clr_w1c_en = sel.wr_stat & (ctrl.mode == CLR_W1C);

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (P_STICKY_MASK[i]) begin : g_sticky
            dmasr_sticky_bit u_bit (
                .clk     (clk),
                .rst     (rst),
                .set_evt (evt_set[i]),
                .clr_rd  (clr_rd_en),
                .clr_w1c (clr_w1c_en & bus_wdata[i]),
                .q       (sticky_q[i])
            );
            assign stat_view[i] = sticky_q[i];
        end else begin : g_live
            assign sticky_q[i]  = 1'b0;
            assign stat_view[i] = live_stat[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (sel.rd_stat)
            rdata_q <= stat_word(stat_view);
        else if (sel.rd_ctrl)
            rdata_q <= ctrl_word(ctrl);
        else
            rdata_q <= '0;
    end

    assign bus_rdata = rdata_q;
    assign irq       = |(sticky_q & ctrl.irq_en);

    // Write-one-to-clear mode: a read alone changes no flag (R5)
    assert_w1c_read_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (sel.rd_stat && !bus_wr && ctrl.mode == CLR_W1C && (evt_set & P_STICKY_MASK) == '0)
        |=> $stable(sticky_q));

    // Clear-on-read mode: a status write alone changes no flag (R4)
    assert_cor_write_ignored_R4: assert property (@(posedge clk) disable iff (rst)
        (sel.wr_stat && !bus_rd && ctrl.mode == CLR_ON_READ && (evt_set & P_STICKY_MASK) == '0)
        |=> $stable(sticky_q));

    // Returned status equals the flags seen in the strobe cycle (R6)
    assert_rdata_preclear_R6: assert property (@(posedge clk) disable iff (rst)
        sel.rd_stat |=> (bus_rdata[STAT_W-1:0] & P_STICKY_MASK) == $past(sticky_q));

    // Pulses at live positions never create sticky state (R8)
    assert_no_stray_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (sticky_q & ~P_STICKY_MASK) == '0);

endmodule

// File: tb/sim_dma_status_clrmode.sv
`timescale 1ns/1ps
module sim_dma_status_clrmode;

    localparam logic [7:0] A_CTRL = 8'h50;
    localparam logic [7:0] A_STAT = 8'h54;
    localparam logic [7:0] MASK   = 8'h4E;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic [7:0]  evt_set = '0;
    logic [7:0]  live_stat = '0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_st;

    always #2 clk = ~clk;

    dma_status_clrmode u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .evt_set   (evt_set),
        .live_stat (live_stat),
        .irq       (irq)
    );

    function automatic logic [7:0] spread(input logic [3:0] n);
        return {1'b0, n[3], 2'b00, n[2], n[1], n[0], 1'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse(input logic [7:0] e);
        @(negedge clk);
        evt_set = e;
        @(negedge clk);
        evt_set = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 rdata", bus_rdata, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);
        do_read(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
        do_read(A_STAT, d); chk("R1 status", d, 32'h0);

        // R2 control field layout
        do_write(A_CTRL, 32'hFFFF_FFFF);
        do_read(A_CTRL, d); chk("R2 ctrl readback", d, 32'h0100_004E);
        // R6 unmapped offset and idle cycle
        do_read(8'h10, d); chk("R6 unmapped", d, 32'h0);
        @(negedge clk); chk("R6 idle rdata", bus_rdata, 32'h0);

        // Exhaustive sweep over modes, flag patterns, clear patterns
        exp_st = '0;
        for (int m = 0; m < 2; m++) begin
            do_write(A_CTRL, (32'(m) << 24) | 32'h4E);
            for (int p = 0; p < 16; p++) begin
                for (int w = 0; w < 16; w++) begin
                    live_stat = 8'(p * 16 + w);
                    pulse(spread(4'(p)) | 8'hB1);  // R8 stray bits included
                    exp_st = exp_st | spread(4'(p));
                    chk("R7 irq after set", {31'h0, irq}, {31'h0, exp_st != 0});
                    do_write(A_STAT, {24'h0, spread(4'(w))});
                    if (m == 1) exp_st = exp_st & ~spread(4'(w));
                    do_read(A_STAT, d);
                    chk("R3 R6 R8 status", d, {24'h0, exp_st | (live_stat & ~MASK)});
                    if (m == 0) exp_st = '0;
                    do_read(A_STAT, d);
                    chk(m == 1 ? "R5 after read" : "R4 after read", d,
                        {24'h0, exp_st | (live_stat & ~MASK)});
                    chk("R7 irq level", {31'h0, irq}, {31'h0, exp_st != 0});
                    if (m == 1) begin
                        do_write(A_STAT, 32'hFF);
                        exp_st = '0;
                    end
                    chk("R7 irq cleared", {31'h0, irq}, 32'h0);
                end
            end
        end

        live_stat = '0;
        // R3 set wins against clear-on-read
        do_write(A_CTRL, 32'h0000_004E);
        pulse(8'h02);
        @(negedge clk);
        bus_addr = A_STAT; bus_rd = 1'b1; evt_set = 8'h06;
        @(negedge clk);
        bus_rd = 1'b0; evt_set = '0;
        chk("R6 preclear value", bus_rdata, 32'h02);
        do_read(A_STAT, d); chk("R3 set wins on read", d, 32'h06);
        do_read(A_STAT, d); chk("R4 cleared", d, 32'h0);

        // R3 set wins against write-one-to-clear
        do_write(A_CTRL, 32'h0100_004E);
        pulse(8'h48);
        @(negedge clk);
        bus_addr = A_STAT; bus_wr = 1'b1; bus_wdata = 32'h48; evt_set = 8'h08;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; evt_set = '0;
        do_read(A_STAT, d); chk("R3 set wins on w1c", d, 32'h08);
        do_write(A_STAT, 32'h08);

        // R7 enable gating
        do_write(A_CTRL, 32'h0100_0008);
        pulse(8'h02);
        chk("R7 disabled flag", {31'h0, irq}, 32'h0);
        pulse(8'h08);
        chk("R7 enabled flag", {31'h0, irq}, 32'h1);
        do_write(A_STAT, 32'h08);
        chk("R7 drop after clear", {31'h0, irq}, 32'h0);
        do_read(A_STAT, d); chk("R5 bit1 kept", d, 32'h02);

        finish_run();
    end

endmodule